// File: doc/BRIEF.md
# Queue status interrupt aggregator

This block turns the per-queue status flags of a 64-queue manager into two active-high processor interrupt lines. Queues 0 to 31 feed the low line and queues 32 to 63 feed the high line. Every queue has four status inputs: empty, nearly-empty, nearly-full and full. Each queue produces one edge-detected event per cycle. When the queue's enable bit is set, that event latches the queue's bit in a 32-bit pending register for its bank. Each interrupt line is high whenever any bit of its pending register is set.

For a low-bank queue, software chooses which of the four flags is watched and whether its rising or its falling edge counts. A high-bank queue always watches the rising edge of its nearly-empty flag. Software clears pending bits by writing ones. Because only a fresh transition can set a bit, a cleared bit stays clear while the watched condition persists. It can set again only after the condition goes away and comes back. Only the level-triggered, active-high mode of operation is implemented.

A register port gives access to the select, enable and pending registers. Writes take effect on the clock edge and reads are combinational.

Top module: `qstat_irq_agg`

## Requirements
- R1: On reset every select, enable and pending register reads as zero and both `irq_lo` and `irq_hi` are low.
- R2: Queue q (0..31) has a nibble in select register q/8 (address q/8) at bit 4*(q%8). Nibble bits [1:0] pick the watched flag (00 empty, 01 nearly-empty, 10 nearly-full, 11 full). Nibble bit 2 picks the polarity (0 rising, 1 falling). Nibble bit 3 is reserved and reads 0. A watched transition between two consecutive clock edges sets pending bit q at the second edge.
- R3: Queue 32+k sets pending-high bit k only on a rising edge of its nearly-empty flag. The select registers have no effect on it.
- R4: A pending bit can set only while its enable bit is 1 (address 4 covers queues 0..31 and address 5 covers 32..63). Clearing an enable bit leaves an already set pending bit unchanged.
- R5: Writing to address 6 (low bank) or address 7 (high bank) clears each pending bit written as 1 and leaves each bit written as 0 unchanged.
- R6: A cleared pending bit stays clear while the watched condition stays asserted. It sets again once the condition has been removed and then asserted again.
- R7: When a clearing write and an enabled qualifying edge hit the same bit on the same edge, the bit ends up set.
- R8: `irq_lo` is the OR of the low pending register and `irq_hi` is the OR of the high pending register. Both follow their registers with no extra delay.
- R9: `rdata` returns, combinationally, the register at `addr`: 0..3 select, 4..5 enable, 6..7 pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | 64 | Empty flag per queue |
| q_nempty | input | 64 | Nearly-empty flag per queue |
| q_nfull | input | 64 | Nearly-full flag per queue |
| q_full | input | 64 | Full flag per queue |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq_lo | output | 1 | Interrupt for queues 0..31 |
| irq_hi | output | 1 | Interrupt for queues 32..63 |

## Verification
Directed sequences do several things. One drives a falling edge of a chosen flag, which separates polarity from flag choice. One holds a condition asserted after a clear, which shows the difference between edge arming and level arming. One lands a clear on the same edge as a new event, which exposes the priority. One toggles enables around a pending bit. Programming every select field while driving a high-bank queue confirms that those queues ignore selection. A long random phase toggles all four flag vectors sparsely and interleaves random writes to every address. It compares each read and both interrupt lines against a bench model. That phase catches wrong field positions, wrong edge memory after reselection and wrong masking.

// File: rtl/qstat_irq_agg.sv
module qstat_irq_agg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] q_empty,
  input  logic [63:0] q_nempty,
  input  logic [63:0] q_nfull,
  input  logic [63:0] q_full,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq_lo,
  output logic        irq_hi
);
  localparam int BANK = 32;
  localparam int PER_REG = 8;
  localparam logic [31:0] SEL_MASK = 32'h7777_7777;

  logic [3:0][31:0] sel_r;
  logic [BANK-1:0] en_lo, en_hi, st_lo, st_hi;
  logic [BANK-1:0] pv_e, pv_ne, pv_nf, pv_f, pv_ne_hi;
  logic [BANK-1:0] hit_lo, hit_hi, clr_lo, clr_hi;

  for (genvar q = 0; q < BANK; q++) begin : g_lo
    localparam int RI = q / PER_REG;
    localparam int BI = 4 * (q % PER_REG);
    logic [1:0] fsel;
    logic       fall, cur, prv;
    assign fsel = sel_r[RI][BI +: 2];
    assign fall = sel_r[RI][BI + 2];
    always_comb begin
      case (fsel)
        2'b00:   begin cur = q_empty[q];  prv = pv_e[q];  end
        2'b01:   begin cur = q_nempty[q]; prv = pv_ne[q]; end
        2'b10:   begin cur = q_nfull[q];  prv = pv_nf[q]; end
        default: begin cur = q_full[q];   prv = pv_f[q];  end
      endcase
    end
    assign hit_lo[q] = fall ? (prv & ~cur) : (cur & ~prv);
  end

  assign hit_hi = q_nempty[63:32] & ~pv_ne_hi;
  assign clr_lo = (wr_en && addr == 3'd6) ? wdata : '0;
  assign clr_hi = (wr_en && addr == 3'd7) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_r <= '0;
      en_lo <= '0;
      en_hi <= '0;
      st_lo <= '0;
      st_hi <= '0;
      pv_e <= '0;
      pv_ne <= '0;
      pv_nf <= '0;
      pv_f <= '0;
      pv_ne_hi <= '0;
    end else begin
      if (wr_en && addr < 3'd4) sel_r[addr[1:0]] <= wdata & SEL_MASK;
      if (wr_en && addr == 3'd4) en_lo <= wdata;
      if (wr_en && addr == 3'd5) en_hi <= wdata;
      st_lo <= (st_lo & ~clr_lo) | (hit_lo & en_lo);
      st_hi <= (st_hi & ~clr_hi) | (hit_hi & en_hi);
      pv_e <= q_empty[31:0];
      pv_ne <= q_nempty[31:0];
      pv_nf <= q_nfull[31:0];
      pv_f <= q_full[31:0];
      pv_ne_hi <= q_nempty[63:32];
    end
  end

  always_comb begin
    case (addr)
      3'd4:    rdata = en_lo;
      3'd5:    rdata = en_hi;
      3'd6:    rdata = st_lo;
      3'd7:    rdata = st_hi;
      default: rdata = sel_r[addr[1:0]];
    endcase
  end

  assign irq_lo = |st_lo;
  assign irq_hi = |st_hi;

  assert_en_gates_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_lo & ~$past(st_lo) & ~$past(en_lo)) == '0 &&
              (st_hi & ~$past(st_hi) & ~$past(en_hi)) == '0));

  assert_hi_rise_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_hi & ~$past(st_hi) & ~($past(q_nempty[63:32]) & ~$past(pv_ne_hi))) == '0));

  assert_clear_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_lo & ~(hit_lo & en_lo)) & st_lo) == '0));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_lo & hit_lo & en_lo) & ~st_lo) == '0));

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lo) |-> $past(|(hit_lo & en_lo)));
endmodule

// File: tb/tb_qstat_irq_agg.sv
module tb_qstat_irq_agg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] fe = '0, fne = '0, fnf = '0, ff = '0;
  logic wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_lo, irq_hi;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] m_sel [4];
  logic [31:0] m_en_lo, m_en_hi, m_st_lo, m_st_hi;
  logic [63:0] p_e, p_ne, p_nf, p_f;

  always #4 clk = ~clk;

  qstat_irq_agg dut (
    .clk(clk), .rst_n(rst_n),
    .q_empty(fe), .q_nempty(fne), .q_nfull(fnf), .q_full(ff),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd4: return m_en_lo;
      3'd5: return m_en_hi;
      3'd6: return m_st_lo;
      3'd7: return m_st_hi;
      default: return m_sel[a[1:0]];
    endcase
  endfunction

  // expected low-bank events from the encoding stated in R2
  function automatic logic [31:0] m_hits_lo();
    logic [31:0] h;
    for (int q = 0; q < 32; q++) begin
      logic [3:0] nib;
      logic c, p;
      nib = m_sel[q / 8][4 * (q % 8) +: 4];
      case (nib[1:0])
        2'd0: begin c = fe[q];  p = p_e[q];  end
        2'd1: begin c = fne[q]; p = p_ne[q]; end
        2'd2: begin c = fnf[q]; p = p_nf[q]; end
        default: begin c = ff[q]; p = p_f[q]; end
      endcase
      h[q] = nib[2] ? (p && !c) : (c && !p);
    end
    return h;
  endfunction

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd);
    logic [31:0] h_lo, h_hi;
    wr_en = we; addr = a; wdata = wd;
    #1;
    chk("R9 read", rdata, m_read(a));
    h_lo = m_hits_lo();
    h_hi = fne[63:32] & ~p_ne[63:32];
    m_st_lo = (m_st_lo & ~((we && a == 3'd6) ? wd : 32'h0)) | (h_lo & m_en_lo);
    m_st_hi = (m_st_hi & ~((we && a == 3'd7) ? wd : 32'h0)) | (h_hi & m_en_hi);
    if (we && a < 3'd4) m_sel[a[1:0]] = wd & 32'h7777_7777;
    if (we && a == 3'd4) m_en_lo = wd;
    if (we && a == 3'd5) m_en_hi = wd;
    p_e = fe; p_ne = fne; p_nf = fnf; p_f = ff;
    @(posedge clk);
    #2;
    chk("R8 irq_lo", {31'b0, irq_lo}, {31'b0, |m_st_lo});
    chk("R8 irq_hi", {31'b0, irq_hi}, {31'b0, |m_st_hi});
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    wr_en = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
    step(1'b0, a, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) m_sel[i] = '0;
    m_en_lo = '0; m_en_hi = '0; m_st_lo = '0; m_st_hi = '0;
    p_e = '0; p_ne = '0; p_nf = '0; p_f = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    for (int a = 0; a < 8; a++) rd(3'(a), 32'h0, "R1 reset reg");
    chk("R1 irq", {30'b0, irq_hi, irq_lo}, 32'h0);

    // R9 reserved nibble bit masking
    step(1'b1, 3'd1, 32'hFFFF_FFFF);
    rd(3'd1, 32'h7777_7777, "R9 select mask");
    step(1'b1, 3'd1, 32'h0);

    // R2 queue 5 watches nearly-full, falling edge
    step(1'b1, 3'd0, 32'h0060_0000);
    step(1'b1, 3'd4, 32'h0000_0020);
    fnf[5] = 1'b1; step(1'b0, 3'd0, 32'h0);
    rd(3'd6, 32'h0, "R2 rising ignored when falling selected");
    fnf[5] = 1'b0; step(1'b0, 3'd0, 32'h0);
    rd(3'd6, 32'h20, "R2 falling sets bit 5");
    chk("R8 irq_lo up", {31'b0, irq_lo}, 32'h1);

    // R5 write-one-to-clear
    step(1'b1, 3'd6, 32'h0);
    rd(3'd6, 32'h20, "R5 zero write keeps bit");
    step(1'b1, 3'd6, 32'h20);
    rd(3'd6, 32'h0, "R5 one write clears");
    chk("R8 irq_lo down", {31'b0, irq_lo}, 32'h0);

    // R6 no re-set while condition held, re-set after re-assertion
    repeat (4) step(1'b0, 3'd0, 32'h0);
    rd(3'd6, 32'h0, "R6 held condition stays clear");
    fnf[5] = 1'b1; step(1'b0, 3'd0, 32'h0);
    fnf[5] = 1'b0; step(1'b0, 3'd0, 32'h0);
    rd(3'd6, 32'h20, "R6 re-asserted condition sets");

    // R7 clear and new edge on the same edge
    fnf[5] = 1'b1; step(1'b0, 3'd0, 32'h0);
    fnf[5] = 1'b0; step(1'b1, 3'd6, 32'h20);
    rd(3'd6, 32'h20, "R7 edge wins over clear");

    // R4 disabling keeps bit, disabled edges ignored
    step(1'b1, 3'd4, 32'h0);
    rd(3'd6, 32'h20, "R4 disable keeps pending");
    step(1'b1, 3'd6, 32'h20);
    fnf[5] = 1'b1; step(1'b0, 3'd0, 32'h0);
    fnf[5] = 1'b0; step(1'b0, 3'd0, 32'h0);
    rd(3'd6, 32'h0, "R4 disabled edge ignored");

    // R3 high bank: queue 40 = bit 8, select fields ignored
    for (int a = 0; a < 4; a++) step(1'b1, 3'(a), 32'hFFFF_FFFF);
    step(1'b1, 3'd5, 32'h0000_0100);
    fne[40] = 1'b1; step(1'b0, 3'd0, 32'h0);
    rd(3'd7, 32'h100, "R3 nearly-empty rise sets bit 8");
    chk("R8 irq_hi up", {31'b0, irq_hi}, 32'h1);
    step(1'b1, 3'd7, 32'h100);
    fne[40] = 1'b0; ff[40] = 1'b1; fe[40] = 1'b1; step(1'b0, 3'd0, 32'h0);
    rd(3'd7, 32'h0, "R3 falling and other flags ignored");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      fe  ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      fne ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      fnf ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      ff  ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      r = $urandom;
      if (r[1:0] == 2'd0) begin
        logic [2:0] a;
        a = 3'($urandom % 8);
        step(1'b1, a, (a >= 3'd6) ? ($urandom & $urandom) : $urandom);
      end else begin
        step(1'b0, 3'($urandom % 8), 32'h0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule